// File: doc/BRIEF.md
# Pipelined Burst SRAM

A single-clock model of a synchronous burst static RAM with a small array. Every control input is sampled on the rising clock edge. A cycle either opens a burst at an external address, moves through a four-beat burst, holds the current beat, or deselects the device. Writes land in the array at the edge that samples them. Read data goes through an output register, so it reaches the bus one clock edge after the read cycle. When the device is deselected, the output drivers stay on for two more cycles before they release.

A burst can be opened by either of two active-low strobes. The processor strobe is ignored whenever the main chip enable is inactive, and it always opens a read. The controller strobe opens a read or a write, as the write inputs decide. The two secondary enables matter only in a cycle where a strobe is active. The order of the beats within a burst comes from a small order unit, which is either linear or exclusive-or based. Every byte lane carries a ninth bit, a parity bit, which the block stores and returns like the data bits.

The data bus is presented as separate input and output vectors plus a drive enable, which the pad ring turns into a shared bus. An asynchronous active-low output enable masks the drive enable.

Top module: `pburst_sram`

## Requirements
- R1: During and after reset `dq_drive` is low, and the device stays deselected until a strobe opens a burst.
- R2: A cycle with `proc_stb_n` low, `sel_main_n` low, `sel_hi` high and `sel_lo_n` low opens a read burst at `addr`. It never writes the array, whatever the write inputs are.
- R3: While `sel_main_n` is high, `proc_stb_n` is ignored. If `ctrl_stb_n` is low the cycle deselects. If `ctrl_stb_n` is high the cycle continues or holds the current burst.
- R4: A cycle with `ctrl_stb_n` low, `proc_stb_n` high and all three enables active opens a burst at `addr`. It is a write when R8 calls for one and a read otherwise.
- R5: `sel_hi` and `sel_lo_n` are used only in cycles with an active strobe. A strobe cycle in which either of them is inactive deselects. In continue and hold cycles their values have no effect.
- R6: In a cycle with both strobes high, while a burst is open, `adv_n` low steps to the next beat and `adv_n` high repeats the current beat. Either kind of cycle can be a read or a write.
- R7: The beat address replaces the two low address bits and leaves the upper bits alone. Beat k from start value s is (s+k) mod 4 when `seq_xor` is 0, and s XOR k when `seq_xor` is 1.
- R8: `wr_all_n` low writes every lane. Otherwise `wr_lane_n` low writes each lane i whose `lane_wr_n[i]` is low. If no lane is selected this way, the cycle is a read.
- R9: A write takes effect at its sampling edge, so a read issued in the next cycle returns the new data. A read sampled at edge N puts its data on `dq_out`, with `dq_drive` high, after edge N+1.
- R10: When the first cycle of a deselect run is sampled at edge D, `dq_drive` keeps its value after edges D and D+1. It goes low after edge D+2 unless a read is issued at edge D+1.
- R11: Lane i occupies bits [9i+8:9i] of `dq_in` and `dq_out`. Bit 9i+8 is the lane's parity bit, and it is stored, masked and returned exactly like the data bits.
- R12: `out_en_n` high forces `dq_drive` low at once, without waiting for a clock edge. It has no effect on the pipeline, so when it returns low the pending data appears unchanged.
- R13: While the device is deselected, cycles with both strobes high stay deselected. They neither write nor drive, whatever `adv_n` and the write inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | External word address |
| proc_stb_n | input | 1 | Processor burst strobe, active low |
| ctrl_stb_n | input | 1 | Controller burst strobe, active low |
| adv_n | input | 1 | Step to next beat when low, hold when high |
| sel_main_n | input | 1 | Main chip enable, active low |
| sel_hi | input | 1 | Secondary enable, active high |
| sel_lo_n | input | 1 | Secondary enable, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_lane_n | input | 1 | Per-lane write enable, active low |
| lane_wr_n | input | LANES | Per-lane write strobes, active low |
| seq_xor | input | 1 | Beat order: 0 linear, 1 exclusive-or |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | LANES*LANE_BITS | Write data with parity bits |
| dq_out | output | LANES*LANE_BITS | Registered read data |
| dq_drive | output | 1 | Drive enable for the data bus |

## Verification
The processor strobe and a burst continue can land in the same cycle. The bench provokes this by holding `proc_stb_n` low with a fresh address while `sel_main_n` is high and `ctrl_stb_n` is high. It judges the result by whether the next beat of the open burst appears on `dq_out`, not the word at the new address. The two-cycle deselect drain also overlaps the last read of a burst: the bench samples `dq_drive` on each of the three edges after the deselect edge. On those edges it must still hold the final beat, and then release.

// File: rtl/pburst_sram.sv
module pburst_order #(
  parameter int CW = 2
) (
  input  logic [CW-1:0] first,
  input  logic [CW-1:0] step,
  input  logic          xor_seq,
  output logic [CW-1:0] slot
);
  assign slot = xor_seq ? (first ^ step) : (first + step);
endmodule

module pburst_sram #(
  parameter int ADDR_W    = 6,
  parameter int LANES     = 2,
  parameter int LANE_BITS = 9,
  parameter int BURST_W   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       proc_stb_n,
  input  logic                       ctrl_stb_n,
  input  logic                       adv_n,
  input  logic                       sel_main_n,
  input  logic                       sel_hi,
  input  logic                       sel_lo_n,
  input  logic                       wr_all_n,
  input  logic                       wr_lane_n,
  input  logic [LANES-1:0]           lane_wr_n,
  input  logic                       seq_xor,
  input  logic                       out_en_n,
  input  logic [LANES*LANE_BITS-1:0] dq_in,
  output logic [LANES*LANE_BITS-1:0] dq_out,
  output logic                       dq_drive
);
  localparam int W     = LANES * LANE_BITS;
  localparam int DEPTH = 1 << ADDR_W;

  logic [W-1:0] mem [DEPTH];

  logic               active_q, rd_q, wr_q, ds_q, ds2_q, drv_q;
  logic [BURST_W-1:0] cnt_q;
  logic [ADDR_W-1:0]  base_q, rd_addr_q;
  logic [W-1:0]       dout_q;

  logic               sel_all, proc_go, strobe, start, cont, is_dsel;
  logic               wr_req, do_wr, do_rd;
  logic [LANES-1:0]   lane_mask;
  logic [BURST_W-1:0] nxt_cnt, slot;
  logic [ADDR_W-1:0]  base_src, eff;

  assign sel_all  = !sel_main_n && sel_hi && !sel_lo_n;
  assign proc_go  = !proc_stb_n && !sel_main_n;
  assign strobe   = proc_go || !ctrl_stb_n;
  assign start    = strobe && sel_all;
  assign cont     = !strobe && active_q;
  assign is_dsel  = !start && !cont;

  assign lane_mask = !wr_all_n  ? {LANES{1'b1}} :
                     !wr_lane_n ? ~lane_wr_n    : {LANES{1'b0}};
  assign wr_req    = |lane_mask;
  assign do_wr     = wr_req && (cont || (start && !proc_go));
  assign do_rd     = (start || cont) && !do_wr;

  assign nxt_cnt  = start ? '0 : (adv_n ? cnt_q : cnt_q + 1'b1);
  assign base_src = start ? addr : base_q;

  pburst_order #(.CW(BURST_W)) order_i (
    .first  (base_src[BURST_W-1:0]),
    .step   (nxt_cnt),
    .xor_seq(seq_xor),
    .slot   (slot)
  );

  assign eff = {base_src[ADDR_W-1:BURST_W], slot};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      cnt_q     <= '0;
      base_q    <= '0;
      rd_q      <= 1'b0;
      wr_q      <= 1'b0;
      ds_q      <= 1'b1;
      ds2_q     <= 1'b1;
      drv_q     <= 1'b0;
      rd_addr_q <= '0;
      dout_q    <= '0;
    end else begin
      active_q  <= !is_dsel;
      if (!is_dsel) begin
        cnt_q  <= nxt_cnt;
        base_q <= base_src;
      end
      rd_q      <= do_rd;
      wr_q      <= do_wr;
      ds_q      <= is_dsel;
      ds2_q     <= ds_q;
      rd_addr_q <= eff;
      if (rd_q) begin
        dout_q <= mem[rd_addr_q];
        drv_q  <= 1'b1;
      end else if (wr_q || ds2_q) begin
        drv_q  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      for (int i = 0; i < LANES; i++) begin
        if (lane_mask[i]) mem[eff][i*LANE_BITS +: LANE_BITS] <= dq_in[i*LANE_BITS +: LANE_BITS];
      end
    end
  end

  assign dq_out   = dout_q;
  assign dq_drive = drv_q && !out_en_n;
endmodule

// File: rtl/pburst_sram_chk.sv
module pburst_sram_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             proc_stb_n,
  input logic             ctrl_stb_n,
  input logic             sel_main_n,
  input logic             sel_hi,
  input logic             sel_lo_n,
  input logic             wr_all_n,
  input logic             wr_lane_n,
  input logic [LANES-1:0] lane_wr_n,
  input logic             is_dsel,
  input logic             do_wr,
  input logic             active_q,
  input logic             drv_q
);
  logic [1:0] up_q;
  logic       rd_open;

  always_ff @(posedge clk) begin
    if (!rst_n) up_q <= 2'd0;
    else if (up_q != 2'd3) up_q <= up_q + 2'd1;
  end

  assign rd_open = !proc_stb_n && !sel_main_n && sel_hi && !sel_lo_n;

  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !drv_q);

  a_r2_proc_never_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_stb_n && !sel_main_n) |-> !do_wr);

  a_r8_no_lane_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_all_n && (wr_lane_n || (&lane_wr_n))) |-> !do_wr);

  a_r13_idle_stays_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && proc_stb_n && ctrl_stb_n) |-> !do_wr);

  a_r9_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q == 2'd3 && $past(rd_open)) |=> drv_q);

  a_r10_hold_two: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q == 2'd3 && $past(is_dsel, 1) && !$past(is_dsel, 2)) |=> $stable(drv_q));

  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q == 2'd3 && $past(is_dsel, 1) && $past(is_dsel, 2)) |=> !drv_q);
endmodule

bind pburst_sram pburst_sram_chk #(.LANES(LANES)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .proc_stb_n(proc_stb_n),
  .ctrl_stb_n(ctrl_stb_n),
  .sel_main_n(sel_main_n),
  .sel_hi    (sel_hi),
  .sel_lo_n  (sel_lo_n),
  .wr_all_n  (wr_all_n),
  .wr_lane_n (wr_lane_n),
  .lane_wr_n (lane_wr_n),
  .is_dsel   (is_dsel),
  .do_wr     (do_wr),
  .active_q  (active_q),
  .drv_q     (drv_q)
);

// File: tb/pburst_sram_tb.sv
`timescale 1ns/1ps
module pburst_sram_tb_top;
  localparam int ADDR_W = 6;
  localparam int LANES  = 2;
  localparam int LB     = 9;
  localparam int W      = LANES * LB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] addr;
  logic proc_stb_n, ctrl_stb_n, adv_n, sel_main_n, sel_hi, sel_lo_n;
  logic wr_all_n, wr_lane_n, seq_xor, out_en_n;
  logic [LANES-1:0] lane_wr_n;
  logic [W-1:0] dq_in, dq_out;
  logic dq_drive;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pburst_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_BITS(LB), .BURST_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n),
    .adv_n(adv_n), .sel_main_n(sel_main_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
    .wr_all_n(wr_all_n), .wr_lane_n(wr_lane_n), .lane_wr_n(lane_wr_n), .seq_xor(seq_xor),
    .out_en_n(out_en_n), .dq_in(dq_in), .dq_out(dq_out), .dq_drive(dq_drive)
  );

  localparam logic [W-1:0] V5 = {1'b1, 8'hA5, 1'b1, 8'h5A};

  function automatic logic [W-1:0] vpat(input int i);
    return {1'b0, 8'(i), 1'b1, 8'(i + 64)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    proc_stb_n = 1'b1; ctrl_stb_n = 1'b1; adv_n = 1'b1;
    sel_main_n = 1'b0; sel_hi = 1'b1; sel_lo_n = 1'b0;
    wr_all_n = 1'b1; wr_lane_n = 1'b1; lane_wr_n = '1;
    out_en_n = 1'b0; seq_xor = 1'b0; addr = '0; dq_in = '0;
  endtask

  task automatic desel();
    idle();
    sel_main_n = 1'b1; ctrl_stb_n = 1'b0;
  endtask

  task automatic quiet();
    desel();
    repeat (3) tick();
    idle();
  endtask

  task automatic wr_all(input logic [ADDR_W-1:0] a, input logic [W-1:0] d);
    idle();
    ctrl_stb_n = 1'b0; addr = a; wr_all_n = 1'b0; dq_in = d;
    tick();
    idle();
  endtask

  task automatic read_check(input logic [ADDR_W-1:0] a, input logic [W-1:0] exp,
                            input string req, input bit noise);
    idle();
    proc_stb_n = 1'b0; addr = a;
    if (noise) begin wr_all_n = 1'b0; dq_in = '0; end
    tick();
    desel();
    tick();
    check({req, " data"}, 32'(dq_out), 32'(exp));
    check({req, " drive"}, 32'(dq_drive), 32'd1);
    tick(); tick();
    idle();
  endtask

  task automatic t_reset();
    check("R1 drive low in reset", 32'(dq_drive), 32'd0);
    rst_n = 1'b1;
    tick(); tick(); tick();
    check("R1 drive low after reset with idle inputs", 32'(dq_drive), 32'd0);
  endtask

  task automatic t_write_read();
    wr_all(6'd5, V5);
    read_check(6'd5, V5, "R4 R9 R11 write then next-cycle read with parity", 1'b0);
  endtask

  task automatic t_lane_mask();
    wr_all(6'd6, {1'b0, 8'h11, 1'b0, 8'h22});
    idle();
    ctrl_stb_n = 1'b0; addr = 6'd6; wr_lane_n = 1'b0; lane_wr_n = 2'b10;
    dq_in = {1'b1, 8'hFF, 1'b1, 8'hEE};
    tick();
    idle();
    ctrl_stb_n = 1'b0; addr = 6'd6; wr_lane_n = 1'b0; lane_wr_n = 2'b11; dq_in = '1;
    tick();
    quiet();
    read_check(6'd6, {1'b0, 8'h11, 1'b1, 8'hEE}, "R8 R11 lane 0 only, no-lane cycle is read", 1'b0);
  endtask

  task automatic t_proc_forces_read();
    read_check(6'd6, {1'b0, 8'h11, 1'b1, 8'hEE}, "R2 processor strobe read ignores write inputs", 1'b1);
    read_check(6'd6, {1'b0, 8'h11, 1'b1, 8'hEE}, "R2 array unchanged after processor strobe", 1'b0);
  endtask

  task automatic t_blocked_proc();
    for (int i = 8; i < 12; i++) wr_all(ADDR_W'(i), vpat(i));
    quiet();
    proc_stb_n = 1'b0; addr = 6'd8;
    tick();
    idle();
    proc_stb_n = 1'b0; sel_main_n = 1'b1; adv_n = 1'b0; addr = 6'd32;
    tick();
    check("R3 first beat", 32'(dq_out), 32'(vpat(8)));
    desel();
    proc_stb_n = 1'b0;
    tick();
    check("R3 blocked processor strobe continues burst", 32'(dq_out), 32'(vpat(9)));
    tick(); tick();
    check("R3 R10 deselect with both strobes low releases", 32'(dq_drive), 32'd0);
    quiet();
  endtask

  task automatic t_secondary();
    idle();
    proc_stb_n = 1'b0; addr = 6'd8; sel_hi = 1'b0;
    tick();
    desel();
    tick();
    check("R5 start with secondary inactive does not drive", 32'(dq_drive), 32'd0);
    tick();
    check("R5 still quiet", 32'(dq_drive), 32'd0);
    quiet();
    proc_stb_n = 1'b0; addr = 6'd8;
    tick();
    idle();
    adv_n = 1'b0; sel_hi = 1'b0; sel_lo_n = 1'b1;
    tick();
    desel();
    tick();
    check("R5 secondary ignored in continue", 32'(dq_out), 32'(vpat(9)));
    quiet();
  endtask

  task automatic t_burst(input logic [ADDR_W-1:0] a, input logic xr,
                         input int e0, input int e1, input int e2, input int e3);
    idle();
    seq_xor = xr; proc_stb_n = 1'b0; addr = a;
    tick();
    idle();
    seq_xor = xr; adv_n = 1'b0;
    tick();
    check("R7 beat 0", 32'(dq_out), 32'(vpat(e0)));
    tick();
    check("R7 beat 1", 32'(dq_out), 32'(vpat(e1)));
    tick();
    check("R7 beat 2", 32'(dq_out), 32'(vpat(e2)));
    desel();
    tick();
    check("R7 beat 3", 32'(dq_out), 32'(vpat(e3)));
    quiet();
  endtask

  task automatic t_suspend();
    idle();
    proc_stb_n = 1'b0; addr = 6'd8;
    tick();
    idle();
    tick();
    check("R6 first beat", 32'(dq_out), 32'(vpat(8)));
    idle();
    adv_n = 1'b0;
    tick();
    check("R6 hold repeats beat", 32'(dq_out), 32'(vpat(8)));
    desel();
    tick();
    check("R6 advance after hold", 32'(dq_out), 32'(vpat(9)));
    quiet();
    idle();
    ctrl_stb_n = 1'b0; addr = 6'd12; wr_all_n = 1'b0; dq_in = vpat(100);
    tick();
    idle();
    wr_all_n = 1'b0; adv_n = 1'b0; dq_in = vpat(101);
    tick();
    adv_n = 1'b1; dq_in = vpat(102);
    tick();
    adv_n = 1'b0; dq_in = vpat(103);
    tick();
    quiet();
    read_check(6'd12, vpat(100), "R6 burst write beat 0", 1'b0);
    read_check(6'd13, vpat(102), "R6 hold write overwrites beat", 1'b0);
    read_check(6'd14, vpat(103), "R6 burst write advances", 1'b0);
  endtask

  task automatic t_double_deselect();
    idle();
    proc_stb_n = 1'b0; addr = 6'd5;
    tick();
    desel();
    proc_stb_n = 1'b0;
    tick();
    check("R10 drive after deselect edge", 32'(dq_drive), 32'd1);
    check("R10 data", 32'(dq_out), 32'(V5));
    tick();
    check("R10 drive one edge later", 32'(dq_drive), 32'd1);
    tick();
    check("R10 released two edges later", 32'(dq_drive), 32'd0);
    quiet();
  endtask

  task automatic t_out_enable();
    idle();
    proc_stb_n = 1'b0; addr = 6'd5;
    tick();
    idle();
    tick();
    out_en_n = 1'b1;
    #1;
    check("R12 output enable masks drive at once", 32'(dq_drive), 32'd0);
    tick();
    check("R12 masked across an edge", 32'(dq_drive), 32'd0);
    out_en_n = 1'b0;
    #1;
    check("R12 drive restored", 32'(dq_drive), 32'd1);
    check("R12 pipeline data intact", 32'(dq_out), 32'(V5));
    quiet();
  endtask

  task automatic t_idle_deselected();
    idle();
    adv_n = 1'b0; wr_all_n = 1'b0; dq_in = '1;
    repeat (3) tick();
    check("R13 no drive while deselected", 32'(dq_drive), 32'd0);
    idle();
    read_check(6'd5, V5, "R13 no write while deselected", 1'b0);
    read_check(6'd6, {1'b0, 8'h11, 1'b1, 8'hEE}, "R13 neighbour untouched", 1'b0);
  endtask

  initial begin
    idle();
    tick(); tick();
    t_reset();
    t_write_read();
    t_lane_mask();
    t_proc_forces_read();
    t_blocked_proc();
    t_secondary();
    t_burst(6'd10, 1'b0, 10, 11, 8, 9);
    t_burst(6'd9, 1'b1, 9, 8, 11, 10);
    t_suspend();
    t_double_deselect();
    t_out_enable();
    t_idle_deselected();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(100000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule